// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter with Low-Bit Fill

This block sends stereo two's complement PCM samples over a serial I2S link. The bit clock runs at 64 times the frame rate, so each channel takes a 32-bit slot no matter how deep the source sample is. A source hands over one left/right pair at a time through a valid/ready port. A width code with each pair says whether the sample is 16, 24 or 32 bits deep. The block puts the sample's sign bit at the top of its slot and fills the unused low bits by one of two rules. The zero rule writes all zeros, which is the same as an arithmetic left shift. The sign rule copies the sample's sign bit into every pad bit, so a 16-bit -1 stays -1 in 32 bits.

The bit clock, word select and data outputs come from a bit-clock enable pulse supplied by the system. A single-entry holding register decouples the source from frame timing. When no pair is waiting at a frame start, the block sends the previous pair again and flags an underrun for that frame.

Top module: `i2s_fill_tx`

## Requirements
- R1: While reset is held and before the first enable pulse, bclk_o, lrck_o, sdata_o and underrun_o are low and s_ready_o is high.
- R2: bclk_o toggles once for each cycle in which bclk_en_i is high and holds its value otherwise, so one bit period spans two enable pulses.
- R3: lrck_o changes only on a falling bclk_o edge and stays in each state for exactly 32 bit periods, low for the left slot and high for the right slot.
- R4: Each slot is sent MSB first and starts one bit period after the lrck_o edge. A frame is the left slot followed by the right slot, and sdata_o changes only on falling bclk_o edges.
- R5: The sample sits in the low bits of s_left_i/s_right_i. Width code 0 means 16 bits and code 1 means 24 bits; codes 2 and 3 both mean 32 bits. Bits above the chosen depth are ignored, and the sample's top bit becomes slot bit 31.
- R6: When fill_sign_i is 0, the pad bits are all 0. A 16-bit 0xFFFF becomes 0xFFFF0000 and a 16-bit 0x0001 becomes 0x00010000.
- R7: When fill_sign_i is 1, every pad bit equals the sample's sign bit. A 16-bit 0xFFFF becomes 0xFFFFFFFF, a 16-bit 0x0001 becomes 0x00010000, and a 24-bit 0x800000 becomes 0x800000FF.
- R8: At 32-bit depth the slot equals the sample in both fill modes.
- R9: fill_sign_i is sampled only at frame start, together with the pair for that frame. A change during a frame does not alter that frame.
- R10: A pair is accepted when s_valid_i and s_ready_o are both high. s_ready_o is then low until the held pair is taken at the next frame start.
- R11: If no pair is held at a frame start, the previous pair is sent again with its own depth and the fill mode sampled at that frame start, and underrun_o is high for that frame. Before any pair arrives, the repeated pair is zero. underrun_o changes only at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_en_i | input | 1 | Half-bit tick; toggles bclk_o |
| fill_sign_i | input | 1 | Pad rule: 0 zero fill, 1 sign fill |
| s_valid_i | input | 1 | Sample pair valid |
| s_ready_o | output | 1 | Holding register empty |
| s_width_i | input | 2 | Depth code: 0=16, 1=24, 2/3=32 bits |
| s_left_i | input | 32 | Left sample, low-aligned |
| s_right_i | input | 32 | Right sample, low-aligned |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word select, low = left |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame is a repeat |

## Verification
Some properties are checked on every cycle: bclk_o moves only after an enable pulse; lrck_o, sdata_o and underrun_o change only on falling bit-clock edges; word select holds for exactly 32 bit periods; and the ready handshake drops after an accept. The content of the slots is shown only by the bench's scenarios. These rebuild whole frames from the serial line and compare them with pairs padded by each rule at each depth. That includes repeats after underrun and fill-mode changes made in the middle of a frame.

// File: rtl/i2s_fill_pkg.sv
package i2s_fill_pkg;
  typedef enum logic [1:0] {
    DEPTH_16  = 2'd0,
    DEPTH_24  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_32X = 2'd3
  } depth_e;

  localparam int NUM_DEPTHS = 3;

  function automatic int depth_bits(input int idx, input int slot_w);
    case (idx)
      0:       return 16;
      1:       return 24;
      default: return slot_w;
    endcase
  endfunction
endpackage

// File: rtl/i2s_fill_clk.sv
module i2s_fill_clk #(
  parameter int FRAME_W = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_en_i,
  output logic bclk_o,
  output logic lrck_o,
  output logic fall_o,
  output logic start_o
);
  localparam int POS_W = $clog2(FRAME_W);

  logic             bclk_q, lrck_q;
  logic [POS_W-1:0] pos_q, pos_nx;

  assign fall_o  = bclk_en_i & bclk_q;
  assign pos_nx  = pos_q + POS_W'(1);
  // position 1 carries the left MSB: new frame is loaded there
  assign start_o = fall_o && (pos_nx == POS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      if (bclk_en_i) bclk_q <= ~bclk_q;
      if (fall_o) begin
        pos_q  <= pos_nx;
        lrck_q <= pos_nx[POS_W-1];
      end
    end
  end

  assign bclk_o = bclk_q;
  assign lrck_o = lrck_q;
endmodule

// File: rtl/i2s_fill_src.sv
module i2s_fill_src #(
  parameter int SLOT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  output logic                        ready_o,
  input  i2s_fill_pkg::depth_e        width_i,
  input  logic [SLOT_W-1:0]           left_i,
  input  logic [SLOT_W-1:0]           right_i,
  input  logic                        take_i,
  output logic [SLOT_W-1:0]           sel_left_o,
  output logic [SLOT_W-1:0]           sel_right_o,
  output i2s_fill_pkg::depth_e        sel_width_o,
  output logic                        underrun_o
);
  import i2s_fill_pkg::*;

  logic              hold_v;
  logic [SLOT_W-1:0] hold_l, hold_r, last_l, last_r;
  depth_e            hold_w, last_w;
  logic              und_q;
  logic              accept;

  assign ready_o = ~hold_v;
  assign accept  = valid_i & ~hold_v;

  assign sel_left_o  = hold_v ? hold_l : last_l;
  assign sel_right_o = hold_v ? hold_r : last_r;
  assign sel_width_o = hold_v ? hold_w : last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      hold_w <= DEPTH_32;
      last_l <= '0;
      last_r <= '0;
      last_w <= DEPTH_32;
      und_q  <= 1'b0;
    end else begin
      if (accept) begin
        hold_v <= 1'b1;
        hold_l <= left_i;
        hold_r <= right_i;
        hold_w <= width_i;
      end else if (take_i && hold_v) begin
        hold_v <= 1'b0;
      end
      if (take_i) begin
        last_l <= sel_left_o;
        last_r <= sel_right_o;
        last_w <= sel_width_o;
        und_q  <= ~hold_v;
      end
    end
  end

  assign underrun_o = und_q;
endmodule

// File: rtl/i2s_fill_fmt.sv
module i2s_fill_fmt #(
  parameter int SLOT_W = 32
) (
  input  logic [SLOT_W-1:0]    sample_i,
  input  i2s_fill_pkg::depth_e depth_i,
  input  logic                 sign_fill_i,
  output logic [SLOT_W-1:0]    slot_o
);
  import i2s_fill_pkg::*;

  logic [SLOT_W-1:0] cand [NUM_DEPTHS];

  for (genvar g = 0; g < NUM_DEPTHS; g++) begin : g_depth
    localparam int D   = depth_bits(g, SLOT_W);
    localparam int PAD = SLOT_W - D;
    localparam logic [SLOT_W-1:0] MASK =
      (PAD == 0) ? '0 : ((SLOT_W'(1) << PAD) - SLOT_W'(1));
    assign cand[g] = (sample_i << PAD) |
                     ((sign_fill_i && sample_i[D-1]) ? MASK : '0);
  end

  always_comb begin
    case (depth_i)
      DEPTH_16: slot_o = cand[0];
      DEPTH_24: slot_o = cand[1];
      default:  slot_o = cand[2];
    endcase
  end
endmodule

// File: rtl/i2s_fill_shift.sv
module i2s_fill_shift #(
  parameter int FRAME_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      sd_q <= 1'b0;
    end else if (load_i) begin
      sd_q <= frame_i[FRAME_W-1];
      sr_q <= frame_i << 1;
    end else if (shift_i) begin
      sd_q <= sr_q[FRAME_W-1];
      sr_q <= sr_q << 1;
    end
  end

  assign sdata_o = sd_q;
endmodule

// File: rtl/i2s_fill_tx.sv
module i2s_fill_tx #(
  parameter int SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_en_i,
  input  logic              fill_sign_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [1:0]        s_width_i,
  input  logic [SLOT_W-1:0] s_left_i,
  input  logic [SLOT_W-1:0] s_right_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              underrun_o
);
  import i2s_fill_pkg::*;

  localparam int FRAME_W = 2 * SLOT_W;

  logic              fall, start;
  logic [SLOT_W-1:0] sel [2];
  logic [SLOT_W-1:0] slot [2];
  depth_e            sel_w;

  i2s_fill_clk #(.FRAME_W(FRAME_W)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_en_i(bclk_en_i),
    .bclk_o   (bclk_o),
    .lrck_o   (lrck_o),
    .fall_o   (fall),
    .start_o  (start)
  );

  i2s_fill_src #(.SLOT_W(SLOT_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (s_valid_i),
    .ready_o    (s_ready_o),
    .width_i    (depth_e'(s_width_i)),
    .left_i     (s_left_i),
    .right_i    (s_right_i),
    .take_i     (start),
    .sel_left_o (sel[0]),
    .sel_right_o(sel[1]),
    .sel_width_o(sel_w),
    .underrun_o (underrun_o)
  );

  // fill mode is only consumed in the start cycle
  for (genvar c = 0; c < 2; c++) begin : g_chan
    i2s_fill_fmt #(.SLOT_W(SLOT_W)) u_fmt (
      .sample_i   (sel[c]),
      .depth_i    (sel_w),
      .sign_fill_i(fill_sign_i),
      .slot_o     (slot[c])
    );
  end

  i2s_fill_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .shift_i(fall),
    .frame_i({slot[0], slot[1]}),
    .sdata_o(sdata_o)
  );
endmodule

// File: rtl/i2s_fill_chk.sv
module i2s_fill_chk #(
  parameter int SLOT_W = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_en_i,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic bclk_o,
  input logic lrck_o,
  input logic sdata_o,
  input logic underrun_o
);
  localparam int CNT_W = $clog2(SLOT_W) + 1;

  logic [CNT_W-1:0] fall_cnt;
  logic             lrck_q, bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_cnt <= '0;
      lrck_q   <= 1'b0;
      bclk_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_o;
      lrck_q <= lrck_o;
      if (lrck_o != lrck_q) fall_cnt <= '0;
      else if (bclk_q && !bclk_o) fall_cnt <= fall_cnt + CNT_W'(1);
    end
  end

  // R2
  bclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bclk_o) |-> $past(bclk_en_i));

  // R3
  lrck_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_o) |-> $fell(bclk_o));

  // R3
  lrck_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_o != lrck_q) |-> (fall_cnt == CNT_W'(SLOT_W - 1)));

  // R4
  sdata_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(bclk_o));

  // R10
  hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  // R11
  underrun_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(underrun_o) |-> ($fell(bclk_o) && !lrck_o));
endmodule

bind i2s_fill_tx i2s_fill_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bclk_en_i (bclk_en_i),
  .s_valid_i (s_valid_i),
  .s_ready_o (s_ready_o),
  .bclk_o    (bclk_o),
  .lrck_o    (lrck_o),
  .sdata_o   (sdata_o),
  .underrun_o(underrun_o)
);

// File: tb/sim_i2s_fill_tx.sv
`timescale 1ns/1ps
module sim_i2s_fill_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_en_i = 1'b0;
  logic        fill_sign_i = 1'b0;
  logic        s_valid_i = 1'b0;
  logic        s_ready_o;
  logic [1:0]  s_width_i = 2'd0;
  logic [31:0] s_left_i = '0;
  logic [31:0] s_right_i = '0;
  logic        bclk_o, lrck_o, sdata_o, underrun_o;

  int checks = 0;
  int errors = 0;
  logic en_on = 1'b0;

  always #2 clk = ~clk;

  i2s_fill_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_en_i(bclk_en_i),
    .fill_sign_i(fill_sign_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .s_width_i(s_width_i), .s_left_i(s_left_i), .s_right_i(s_right_i),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o),
    .underrun_o(underrun_o)
  );

  always @(posedge clk) bclk_en_i <= en_on & ~bclk_en_i;

  // serial monitor: rebuild frames on rising bit clock
  logic [63:0] cap = '0;
  logic        prev_bclk = 1'b0, prev_lrck = 1'b0;
  int          rise_cnt = 0;
  logic [64:0] cap_q [$];

  always @(negedge clk) begin
    if (bclk_o && !prev_bclk) begin
      rise_cnt = rise_cnt + 1;
      cap = {cap[62:0], sdata_o};
      if (!lrck_o && prev_lrck) cap_q.push_back({underrun_o, cap});
      prev_lrck = lrck_o;
    end
    prev_bclk = bclk_o;
  end

  task automatic chk(input logic ok, input string tag,
                     input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(input logic [31:0] s, input logic [1:0] w,
                                      input logic f);
    case (w)
      2'd0:    return {s[15:0], (f && s[15]) ? 16'hFFFF : 16'h0000};
      2'd1:    return {s[23:0], (f && s[23]) ? 8'hFF : 8'h00};
      default: return s;
    endcase
  endfunction

  logic [31:0] el [4];
  logic [31:0] er [4];
  logic [1:0]  ew [4];
  logic        ef [4];

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!bclk_o && !lrck_o && !sdata_o && !underrun_o && s_ready_o, "R1 outputs in reset",
        {60'd0, bclk_o, lrck_o, sdata_o, underrun_o, s_ready_o}, 65'd1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bclk_o && !lrck_o && !sdata_o && !underrun_o && s_ready_o, "R1 idle before enable",
        {60'd0, bclk_o, lrck_o, sdata_o, underrun_o, s_ready_o}, 65'd1);
  endtask

  task automatic t_startup();
    en_on = 1'b1;
    repeat (700) @(negedge clk);
    chk(cap_q.size() >= 1, "R11 frames while empty", 65'(cap_q.size()), 65'd1);
    if (cap_q.size() >= 1)
      chk(cap_q[0] == {1'b1, 64'd0}, "R11 zero repeat before data", cap_q[0], {1'b1, 64'd0});
  endtask

  task automatic t_clock();
    int r0, r1;
    r0 = rise_cnt;
    repeat (512) @(negedge clk);
    chk(rise_cnt - r0 == 128, "R2 bit clock rate", 65'(rise_cnt - r0), 65'd128);
    @(posedge lrck_o); @(negedge clk);
    r0 = rise_cnt;
    @(negedge lrck_o); @(negedge clk);
    r1 = rise_cnt;
    chk(r1 - r0 == 32, "R3 right slot length", 65'(r1 - r0), 65'd32);
    @(posedge lrck_o); @(negedge clk);
    chk(rise_cnt - r1 == 32, "R3 left slot length", 65'(rise_cnt - r1), 65'd32);
  endtask

  task automatic run_stream(input int n, input logic post_fill, input string tag);
    int idx;
    logic [64:0] e;
    cap_q.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!s_ready_o) @(negedge clk);
      fill_sign_i = ef[i];
      s_left_i = el[i]; s_right_i = er[i]; s_width_i = ew[i];
      s_valid_i = 1'b1;
      @(negedge clk);
      s_valid_i = 1'b0;
      chk(!s_ready_o, {"R10 ready drops after accept ", tag}, {64'd0, s_ready_o}, 65'd0);
    end
    while (!s_ready_o) @(negedge clk);
    fill_sign_i = post_fill;
    repeat (1024) @(negedge clk);
    idx = -1;
    for (int k = 0; k < cap_q.size(); k++)
      if (idx < 0 && !cap_q[k][64]) idx = k;
    chk(idx >= 0 && idx + n < cap_q.size(), {"R11 frame count ", tag},
        65'(cap_q.size()), 65'(n + 1));
    if (idx >= 0 && idx + n < cap_q.size()) begin
      for (int i = 0; i < n; i++) begin
        e = {1'b0, fmt(el[i], ew[i], ef[i]), fmt(er[i], ew[i], ef[i])};
        chk(cap_q[idx + i] == e, tag, cap_q[idx + i], e);
      end
      e = {1'b1, fmt(el[n-1], ew[n-1], post_fill), fmt(er[n-1], ew[n-1], post_fill)};
      chk(cap_q[idx + n] == e, {"R11 repeat after ", tag}, cap_q[idx + n], e);
    end
  endtask

  task automatic t_zero16();
    el[0] = 32'hDEADFFFF; er[0] = 32'h00000001; ew[0] = 2'd0; ef[0] = 1'b0;
    run_stream(1, 1'b0, "R6 R5 zero fill 16");
  endtask

  task automatic t_sign16();
    el[0] = 32'h0000FFFF; er[0] = 32'hFFFF0001; ew[0] = 2'd0; ef[0] = 1'b1;
    run_stream(1, 1'b1, "R7 sign fill 16");
  endtask

  task automatic t_depth24();
    el[0] = 32'h00800000; er[0] = 32'h007FFFFF; ew[0] = 2'd1; ef[0] = 1'b1;
    el[1] = 32'hAA800000; er[1] = 32'h117FFFFF; ew[1] = 2'd1; ef[1] = 1'b0;
    run_stream(2, 1'b0, "R5 R7 depth 24");
  endtask

  task automatic t_depth32();
    el[0] = 32'h80000001; er[0] = 32'h12345678; ew[0] = 2'd2; ef[0] = 1'b1;
    el[1] = 32'hFFFFFFFF; er[1] = 32'h80000000; ew[1] = 2'd3; ef[1] = 1'b0;
    run_stream(2, 1'b1, "R8 depth 32");
  endtask

  task automatic t_mixed();
    el[0] = 32'h00008000; er[0] = 32'h00001234; ew[0] = 2'd0; ef[0] = 1'b1;
    el[1] = 32'h00ABCDEF; er[1] = 32'h00FF0000; ew[1] = 2'd1; ef[1] = 1'b0;
    el[2] = 32'h00FFFFFF; er[2] = 32'h00000001; ew[2] = 2'd1; ef[2] = 1'b1;
    run_stream(3, 1'b0, "R9 R4 mixed back to back");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual cycles 150000 expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_clock();
    t_zero16();
    t_sign16();
    t_depth24();
    t_depth32();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule